// File: doc/BRIEF.md
# Pad Control Register Bank

This block holds one nine-bit control word for each of 48 user I/O pads and sits between the core's per-pin output and output-enable signals and the pad drivers. Software reaches the words over a simple request/write-enable register bus. Each word has three write views. The plain view overwrites the word. The set view ORs the written value into the word. The clear view removes the written ones from the word. With these two views, firmware can change single bits without a read-modify-write.

For each pad the block works out four results. It computes whether the pad driver is enabled and the value it drives. It computes the resolved pin level, using the pull controls when nothing drives the pin. It computes the input value seen by the core. Drive strength, slew rate and input hysteresis are stored and exported as static controls only. Every pad leaves reset isolated and output-disabled. Nothing reaches a pin until software clears both of those bits, for example with one write of 0x180 through the clear view.

Top module: `pad_ctrl_bank`

## Requirements
- R1: After reset every pad word reads 0x192: isolate (bit 8) = 1, output-disable (bit 7) = 1, input-enable (bit 6) = 0, drive (bits 5:4) = 01, pull-up (bit 3) = 0, pull-down (bit 2) = 0, hysteresis (bit 1) = 1, fast-slew (bit 0) = 0.
- R2: A write to byte address 4 + 4*n (n = 0..47) replaces word n with wdata[8:0]. A read at that address returns the word in rdata[8:0] with bits 31:9 zero, and rvalid_o is high in the cycle after the read request.
- R3: A write to the plain address + 0x2000 ORs wdata[8:0] into the word and keeps every bit that was already set.
- R4: A write to the plain address + 0x3000 clears the word bits that are 1 in wdata[8:0] and leaves the others. Writing 0x180 there clears isolate and output-disable together.
- R5: pad_oe_o[n] is 1 only when core_oe_i[n] is 1 and both isolate and output-disable of word n are 0. pad_out_o[n] equals core_out_i[n] while driven and 0 otherwise.
- R6: pin_o[n] equals core_out_i[n] while the pad is driven. When undriven it is 1 if pull-up is set (pull-up wins over pull-down), else 0 if pull-down is set, else pin_ext_i[n].
- R7: core_in_o[n] equals pin_o[n] when input-enable is 1 and is 0 when input-enable is 0.
- R8: pad_drive_o[2n+1:2n], pad_slew_o[n], pad_schmitt_o[n], pad_pu_o[n] and pad_pd_o[n] always show the current drive, fast-slew, hysteresis, pull-up and pull-down bits of word n.
- R9: Writes to byte offset 0, to offsets not a multiple of 4, to offsets beyond pad 47 or to the +0x1000 view change no word. Reads from offset 0, misaligned offsets or offsets beyond pad 47 return 0.
- R10: A read through the +0x1000, +0x2000 or +0x3000 view returns the same word value as the plain address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 14 | Byte address; bits 13:12 pick the view |
| wdata_i | input | 32 | Write data |
| rvalid_o | output | 1 | Read data valid, one cycle after a read request |
| rdata_o | output | 32 | Read data |
| core_out_i | input | 48 | Core output value per pad |
| core_oe_i | input | 48 | Core output enable per pad |
| pin_ext_i | input | 48 | External level on an undriven, unpulled pin |
| pad_oe_o | output | 48 | Effective pad driver enable |
| pad_out_o | output | 48 | Value driven onto the pad |
| pad_pu_o | output | 48 | Pull-up control |
| pad_pd_o | output | 48 | Pull-down control |
| pad_drive_o | output | 96 | Drive strength code per pad (00=2 mA, 01=4 mA, 10=8 mA, 11=12 mA) |
| pad_slew_o | output | 48 | Fast-slew control |
| pad_schmitt_o | output | 48 | Input hysteresis control |
| pin_o | output | 48 | Resolved pin level |
| core_in_o | output | 48 | Input value returned to the core |

## Verification
A corrupted control word shows up at the ports at once. The static control outputs and the driver enable follow the word combinationally, so a bad bit is visible in the same cycle it is stored. The read port shows it one cycle after a read. A decode fault that lands a write on the wrong word, or on any word at all for an unmapped address, stays hidden until that word is read back or its pad is exercised. For that reason the bench reads back neighbouring and unmapped locations after every kind of write.

// File: rtl/pad_pkg.sv
package pad_pkg;
  localparam int CFG_W = 9;

  typedef struct packed {
    logic       iso;
    logic       od;
    logic       ie;
    logic [1:0] drive;
    logic       pue;
    logic       pde;
    logic       schmitt;
    logic       slewfast;
  } pad_cfg_t;

  localparam logic [CFG_W-1:0] CFG_RST = 9'h192;

  // Address bits [13:12] select the write view
  localparam logic [1:0] VIEW_PLAIN = 2'd0;
  localparam logic [1:0] VIEW_SET   = 2'd2;
  localparam logic [1:0] VIEW_CLR   = 2'd3;

  typedef enum logic [1:0] {WR_NONE, WR_PLAIN, WR_SET, WR_CLR} wr_op_e;
endpackage

// File: rtl/pad_bus_decode.sv
module pad_bus_decode
  import pad_pkg::*;
#(
  parameter int NUM_PADS = 48,
  parameter int ADDR_W   = 14,
  parameter int IDX_W    = $clog2(NUM_PADS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  output logic                hit_o,
  output logic [IDX_W-1:0]    idx_o,
  output wr_op_e              op_o,
  output logic [NUM_PADS-1:0] sel_o
);
  localparam int OFF_W  = ADDR_W - 2;
  localparam int WORD_W = OFF_W - 2;
  localparam logic [WORD_W-1:0] NP = WORD_W'(NUM_PADS);

  logic [1:0]        view;
  logic [OFF_W-1:0]  off;
  logic [WORD_W-1:0] word, word_m1;

  assign view    = addr_i[ADDR_W-1 -: 2];
  assign off     = addr_i[OFF_W-1:0];
  assign word    = off[OFF_W-1:2];
  assign word_m1 = word - WORD_W'(1);
  assign hit_o   = (off[1:0] == 2'b00) && (word != '0) && (word_m1 < NP);
  assign idx_o   = word_m1[IDX_W-1:0];

  always_comb begin
    op_o = WR_NONE;
    if (req_i && we_i && hit_o) begin
      unique case (view)
        VIEW_PLAIN: op_o = WR_PLAIN;
        VIEW_SET:   op_o = WR_SET;
        VIEW_CLR:   op_o = WR_CLR;
        default:    op_o = WR_NONE;
      endcase
    end
  end

  always_comb begin
    sel_o = '0;
    for (int i = 0; i < NUM_PADS; i++)
      if (op_o != WR_NONE && int'(idx_o) == i) sel_o[i] = 1'b1;
  end

  AST_SEL_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_o)); // R9
  AST_NO_WRITE_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && !hit_o) |-> (sel_o == '0)); // R9
endmodule

// File: rtl/pad_cfg_reg.sv
module pad_cfg_reg
  import pad_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_i,
  input  wr_op_e           op_i,
  input  logic [CFG_W-1:0] wdata_i,
  output pad_cfg_t         q_o
);
  logic [CFG_W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= CFG_RST;
    else if (sel_i) begin
      unique case (op_i)
        WR_PLAIN: q <= wdata_i;
        WR_SET:   q <= q | wdata_i;
        WR_CLR:   q <= q & ~wdata_i;
        default:  q <= q;
      endcase
    end
  end

  assign q_o = pad_cfg_t'(q);

  AST_SET_ADDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && op_i == WR_SET) |=> ((q & $past(wdata_i)) == $past(wdata_i))); // R3
  AST_SET_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && op_i == WR_SET) |=> ((q & $past(q)) == $past(q))); // R3
  AST_CLR_REMOVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && op_i == WR_CLR) |=> ((q & $past(wdata_i)) == '0)); // R4
  AST_HOLD_UNSEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |=> $stable(q)); // R9
endmodule

// File: rtl/pad_io_cell.sv
module pad_io_cell
  import pad_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  pad_cfg_t cfg_i,
  input  logic     core_out_i,
  input  logic     core_oe_i,
  input  logic     ext_i,
  output logic     oe_o,
  output logic     out_o,
  output logic     pin_o,
  output logic     core_in_o
);
  assign oe_o  = core_oe_i & ~cfg_i.od & ~cfg_i.iso;
  assign out_o = oe_o & core_out_i;

  always_comb begin
    if (oe_o)            pin_o = core_out_i;
    else if (cfg_i.pue)  pin_o = 1'b1;
    else if (cfg_i.pde)  pin_o = 1'b0;
    else                 pin_o = ext_i;
  end

  assign core_in_o = cfg_i.ie & pin_o;

  AST_ISO_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.iso || cfg_i.od) |-> !oe_o); // R5
  AST_PULLUP_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!oe_o && cfg_i.pue) |-> pin_o); // R6
  AST_IN_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_i.ie |-> !core_in_o); // R7
endmodule

// File: rtl/pad_ctrl_bank.sv
module pad_ctrl_bank
  import pad_pkg::*;
#(
  parameter int NUM_PADS = 48,
  parameter int ADDR_W   = 14,
  parameter int DATA_W   = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_i,
  input  logic                  we_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  output logic                  rvalid_o,
  output logic [DATA_W-1:0]     rdata_o,
  input  logic [NUM_PADS-1:0]   core_out_i,
  input  logic [NUM_PADS-1:0]   core_oe_i,
  input  logic [NUM_PADS-1:0]   pin_ext_i,
  output logic [NUM_PADS-1:0]   pad_oe_o,
  output logic [NUM_PADS-1:0]   pad_out_o,
  output logic [NUM_PADS-1:0]   pad_pu_o,
  output logic [NUM_PADS-1:0]   pad_pd_o,
  output logic [2*NUM_PADS-1:0] pad_drive_o,
  output logic [NUM_PADS-1:0]   pad_slew_o,
  output logic [NUM_PADS-1:0]   pad_schmitt_o,
  output logic [NUM_PADS-1:0]   pin_o,
  output logic [NUM_PADS-1:0]   core_in_o
);
  localparam int IDX_W = $clog2(NUM_PADS);

  logic                hit;
  logic [IDX_W-1:0]    idx;
  wr_op_e              op;
  logic [NUM_PADS-1:0] sel;
  pad_cfg_t            cfg [NUM_PADS];
  pad_cfg_t            rd_cfg;
  logic                rd_req;

  pad_bus_decode #(.NUM_PADS(NUM_PADS), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dec (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i,
    .hit_o(hit), .idx_o(idx), .op_o(op), .sel_o(sel)
  );

  for (genvar g = 0; g < NUM_PADS; g++) begin : g_pad
    pad_cfg_reg u_reg (
      .clk_i, .rst_ni, .sel_i(sel[g]), .op_i(op),
      .wdata_i(wdata_i[CFG_W-1:0]), .q_o(cfg[g])
    );
    pad_io_cell u_io (
      .clk_i, .rst_ni, .cfg_i(cfg[g]),
      .core_out_i(core_out_i[g]), .core_oe_i(core_oe_i[g]), .ext_i(pin_ext_i[g]),
      .oe_o(pad_oe_o[g]), .out_o(pad_out_o[g]), .pin_o(pin_o[g]), .core_in_o(core_in_o[g])
    );
    assign pad_pu_o[g]          = cfg[g].pue;
    assign pad_pd_o[g]          = cfg[g].pde;
    assign pad_drive_o[2*g +: 2] = cfg[g].drive;
    assign pad_slew_o[g]        = cfg[g].slewfast;
    assign pad_schmitt_o[g]     = cfg[g].schmitt;
  end

  always_comb begin
    rd_cfg = '0;
    for (int i = 0; i < NUM_PADS; i++)
      if (int'(idx) == i) rd_cfg = cfg[i];
  end

  assign rd_req = req_i & ~we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= rd_req;
      if (rd_req) rdata_o <= hit ? {{(DATA_W-CFG_W){1'b0}}, rd_cfg} : '0;
    end
  end

  AST_RVALID_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req |=> rvalid_o); // R2
  AST_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> (rdata_o[DATA_W-1:CFG_W] == '0)); // R2
  AST_MISS_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req && !hit) |=> (rdata_o == '0)); // R9
endmodule

// File: tb/pad_ctrl_bank_tb.sv
module pad_ctrl_bank_tb;
  localparam int N = 48;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [13:0] addr = '0;
  logic [31:0] wdata = '0;
  logic rvalid;
  logic [31:0] rdata;
  logic [N-1:0] core_out = '1, core_oe = '1, ext = '0;
  logic [N-1:0] oe_o, out_o, pu_o, pd_o, slew_o, sch_o, pin_o, cin_o;
  logic [2*N-1:0] drv_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  pad_ctrl_bank u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rvalid_o(rvalid), .rdata_o(rdata),
    .core_out_i(core_out), .core_oe_i(core_oe), .pin_ext_i(ext),
    .pad_oe_o(oe_o), .pad_out_o(out_o), .pad_pu_o(pu_o), .pad_pd_o(pd_o),
    .pad_drive_o(drv_o), .pad_slew_o(slew_o), .pad_schmitt_o(sch_o),
    .pin_o(pin_o), .core_in_o(cin_o)
  );

  task automatic chk(string tag, logic [95:0] act, logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(logic [13:0] a, logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  // driver: pushes the expected read value, monitor compares
  task automatic bus_rd(logic [13:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    req = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rvalid) begin
      if (exp_q.size() == 0) chk("R2 unexpected rvalid", 96'd1, 96'd0);
      else chk(tag_q.pop_front(), {64'd0, rdata}, {64'd0, exp_q.pop_front()});
    end
  end

  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset words
    bus_rd(14'h004, 32'h192, "R1 pad0 reset");
    bus_rd(14'h060, 32'h192, "R1 pad23 reset");
    bus_rd(14'h0C0, 32'h192, "R1 pad47 reset");
    settle();
    chk("R5 no drive after reset", {48'd0, oe_o}, 96'd0);
    chk("R6 floating pins follow ext", {48'd0, pin_o}, 96'd0);
    chk("R8 drive code reset", drv_o, {48{2'b01}});
    chk("R8 schmitt reset", {48'd0, sch_o}, {48'd0, {N{1'b1}}});
    chk("R8 slew reset", {48'd0, slew_o}, 96'd0);

    // R4 clear isolate+disable on pad 5
    bus_wr(14'h3018, 32'h180);
    bus_rd(14'h018, 32'h012, "R4 clr 0x180 pad5");
    settle();
    chk("R5 pad5 driven", 96'(oe_o[5]), 96'd1);
    chk("R5 pad5 out value", 96'(out_o[5]), 96'd1);
    chk("R6 pad5 pin driven", 96'(pin_o[5]), 96'd1);
    chk("R7 pad5 ie=0 input", 96'(cin_o[5]), 96'd0);
    chk("R5 pad4 untouched", 96'(oe_o[4]), 96'd0);

    // R3 set input enable
    bus_wr(14'h2018, 32'h040);
    bus_rd(14'h018, 32'h052, "R3 set ie pad5");
    settle();
    chk("R7 pad5 ie=1 input", 96'(cin_o[5]), 96'd1);
    core_oe[5] = 1'b0;
    #1;
    chk("R6 pad5 undriven ext0", 96'(pin_o[5]), 96'd0);
    chk("R5 pad5 out gated", 96'(out_o[5]), 96'd0);
    ext[5] = 1'b1;
    #1;
    chk("R7 pad5 ext1 seen", 96'(cin_o[5]), 96'd1);
    core_oe[5] = 1'b1;
    ext[5] = 1'b0;

    // R2 plain write, upper bits dropped; pull-up beats pull-down
    bus_wr(14'h0C0, 32'hFFFF_FE0C);
    bus_rd(14'h0C0, 32'h00C, "R2 plain write pad47");
    settle();
    chk("R8 pad47 pu", 96'(pu_o[47]), 96'd1);
    chk("R8 pad47 pd", 96'(pd_o[47]), 96'd1);
    core_oe[47] = 1'b0;
    #1;
    chk("R6 pad47 pullup wins", 96'(pin_o[47]), 96'd1);
    chk("R7 pad47 ie=0", 96'(cin_o[47]), 96'd0);
    core_oe[47] = 1'b1;

    // pad 10: pull-down then no pull
    ext[10] = 1'b1;
    core_oe[10] = 1'b0;
    bus_wr(14'h02C, 32'h044);
    settle();
    chk("R6 pad10 pulldown", 96'(pin_o[10]), 96'd0);
    chk("R7 pad10 pulled low in", 96'(cin_o[10]), 96'd0);
    bus_wr(14'h02C, 32'h040);
    settle();
    chk("R6 pad10 ext level", 96'(pin_o[10]), 96'd1);
    chk("R7 pad10 ext seen", 96'(cin_o[10]), 96'd1);

    // R8 static controls on pad 3
    bus_wr(14'h010, 32'h031);
    settle();
    chk("R8 pad3 drive 12mA", 96'(drv_o[7:6]), 96'd3);
    chk("R8 pad3 slew", 96'(slew_o[3]), 96'd1);
    chk("R8 pad3 schmitt", 96'(sch_o[3]), 96'd0);
    chk("R5 pad3 driven", 96'(oe_o[3]), 96'd1);
    bus_wr(14'h2010, 32'h080);
    settle();
    chk("R5 pad3 od blocks", 96'(oe_o[3]), 96'd0);
    bus_rd(14'h010, 32'h0B1, "R3 pad3 od set keeps bits");

    // R9 unmapped writes change nothing
    bus_wr(14'h0000, 32'h0);
    bus_wr(14'h00C4, 32'h0);
    bus_wr(14'h1004, 32'h0);
    bus_wr(14'h0006, 32'h0);
    bus_wr(14'h3000, 32'h1FF);
    bus_rd(14'h004, 32'h192, "R9 pad0 unchanged");
    bus_rd(14'h008, 32'h192, "R9 pad1 unchanged");
    bus_rd(14'h0C0, 32'h00C, "R9 pad47 unchanged");
    bus_rd(14'h000, 32'h0, "R9 offset0 reads 0");
    bus_rd(14'h0C4, 32'h0, "R9 past end reads 0");
    bus_rd(14'h006, 32'h0, "R9 misaligned reads 0");

    // R10 views read the same word
    bus_rd(14'h1018, 32'h052, "R10 view1 read");
    bus_rd(14'h2018, 32'h052, "R10 set view read");
    bus_rd(14'h3018, 32'h052, "R10 clr view read");

    repeat (2) @(negedge clk);
    chk("R2 all reads answered", 96'(exp_q.size()), 96'd0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule